// File: doc/BRIEF.md
# Wide-Bus Transfer Byte Counter

This block tracks how many bytes a block-move engine moves over a data bus that runs either 8 or 16 bits wide. It keeps two counters. The move tally is 24 bits wide and cannot be written. It restarts at zero when each move begins. It advances in bus-width units, so on a 16-bit bus it counts two per beat, whatever the byte lanes carry. One exception applies: in a 16-bit send, the first beat may carry a leftover chain byte that the previous move already counted. That byte is not counted again here.

The running total is 32 bits wide and can be loaded by a register write. It adds the number of byte lanes that are actually valid in each beat. Its total is therefore exact, and it includes any chain byte.

A move opens on a start strobe and closes on an end strobe. The bus width is sampled with the start strobe. So is the chain-byte-pending flag, which only takes effect for a 16-bit send. Both counters are registered outputs. They change on the clock edge after the beat, load or start that moves them.

Top module: `xfer_byte_tally`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the move tally and the running total both read zero.
- R2: A cycle with `mv_start` high clears the move tally. Any beat in that same cycle is counted by neither counter.
- R3: In a move opened with `wide_mode` low, each beat adds 1 to the move tally. It adds `beat_lanes[0]` to the running total; `beat_lanes[1]` is ignored.
- R4: In a move opened with `wide_mode` high and `dir_send` high, each beat adds 2 to the move tally regardless of `beat_lanes`. A send with an odd byte total therefore reads one more than the bytes sent.
- R5: The same rule as R4 applies to a wide move opened with `dir_send` low (receive): 2 per beat, one over on an odd total.
- R6: If `chain_pend` is high with `mv_start` in a wide send move, the first beat of that move adds 1 to the move tally instead of 2. In a receive or narrow move, `chain_pend` has no effect.
- R7: In a wide move, each beat adds the count of set bits in `beat_lanes[1:0]` (0, 1 or 2) to the running total. In a narrow move the per-beat amount is R3's `beat_lanes[0]`.
- R8: `ld_en` writes `ld_data` into the running total. If a beat lands in the same cycle, the load wins and that beat's increment to the total is dropped.
- R9: The running total wraps modulo 2^32 with no indication. For example, all-ones plus 2 reads 1.
- R10: A beat in the `mv_end` cycle is still counted. After that, beats change neither counter, and the move tally holds its value until the next `mv_start`.
- R11: Changes to `wide_mode`, `dir_send` or `chain_pend` while a move is open do not alter how that move is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mv_start | input | 1 | Block move begins (one-cycle strobe) |
| mv_end | input | 1 | Block move ends (one-cycle strobe) |
| wide_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus; sampled at move start |
| dir_send | input | 1 | 1 = send, 0 = receive; sampled at move start |
| chain_pend | input | 1 | Leftover chain byte precedes this move's data; sampled at move start |
| beat_vld | input | 1 | One bus beat transferred this cycle |
| beat_lanes | input | 2 | Valid byte lanes of the beat; bit 0 low lane, bit 1 high lane |
| ld_en | input | 1 | Write strobe for the running total |
| ld_data | input | 32 | Value written into the running total |
| move_cnt | output | 24 | Move tally |
| total_cnt | output | 32 | Running total |

## Verification
The assertions check these rules on every cycle:
- a start clears the tally (R2);
- a narrow beat steps the tally by exactly one (R3);
- a wide beat steps it by one or two (R4–R6);
- a load sets the total on the next edge (R8);
- without a beat the tally holds (R10);
- without a beat or a load the total holds.

Some behaviour only the bench's scenarios can show: the exact one-over reading on odd wide sends and receives, and that the chain byte is left out only on the first beat of a send. They also cover the mode flags being ignored mid-move, and wrap-around of the total from all-ones.

// File: rtl/xbt_pkg.sv
package xbt_pkg;

  localparam int STEP_W = 2;

  // Move-tally step for one beat: bus width in bytes, less the chain byte
  // that rides the first beat of a chained wide send.
  function automatic logic [STEP_W-1:0] move_step(input logic wide, input logic chain_first);
    logic [STEP_W-1:0] s;
    if (!wide)            s = 2'd1;
    else if (chain_first) s = 2'd1;
    else                  s = 2'd2;
    return s;
  endfunction

  // Running-total step: valid lanes that exist at this bus width.
  function automatic logic [STEP_W-1:0] lane_bytes(input logic wide, input logic [1:0] lanes);
    logic [STEP_W-1:0] n;
    if (wide) n = {1'b0, lanes[0]} + {1'b0, lanes[1]};
    else      n = {1'b0, lanes[0]};
    return n;
  endfunction

endpackage

// File: rtl/xbt_accum.sv
module xbt_accum #(
  parameter int W     = 24,
  parameter int INC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld,
  input  logic [W-1:0]     ld_val,
  input  logic             inc_en,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     q
);
  localparam int PAD = W - INC_W;

  logic [W-1:0] inc_ext;
  assign inc_ext = {{PAD{1'b0}}, inc};

  // Priority: clear, then load, then increment (wraps modulo 2^W).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (clr)    q <= '0;
    else if (ld)     q <= ld_val;
    else if (inc_en) q <= q + inc_ext;
  end
endmodule

// File: rtl/xbt_move_ctl.sv
module xbt_move_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic mv_start,
  input  logic mv_end,
  input  logic wide_mode,
  input  logic dir_send,
  input  logic chain_pend,
  input  logic beat_vld,
  output logic beat_take,
  output logic wide_q,
  output logic chain_first
);
  logic active_q;
  logic chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wide_q   <= 1'b0;
      chain_q  <= 1'b0;
    end else if (mv_start) begin
      active_q <= 1'b1;
      wide_q   <= wide_mode;
      chain_q  <= chain_pend & wide_mode & dir_send;
    end else begin
      if (mv_end)    active_q <= 1'b0;
      if (beat_take) chain_q  <= 1'b0;
    end
  end

  assign beat_take   = active_q & beat_vld & ~mv_start;
  assign chain_first = beat_take & chain_q;
endmodule

// File: rtl/xbt_step.sv
module xbt_step
  import xbt_pkg::*;
(
  input  logic              wide_q,
  input  logic              chain_first,
  input  logic [1:0]        beat_lanes,
  output logic [STEP_W-1:0] move_inc,
  output logic [STEP_W-1:0] total_inc
);
  always_comb begin
    move_inc  = move_step(wide_q, chain_first);
    total_inc = lane_bytes(wide_q, beat_lanes);
  end
endmodule

// File: rtl/xfer_byte_tally.sv
module xfer_byte_tally
  import xbt_pkg::*;
#(
  parameter int MOVE_W = 24,
  parameter int TOT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mv_start,
  input  logic              mv_end,
  input  logic              wide_mode,
  input  logic              dir_send,
  input  logic              chain_pend,
  input  logic              beat_vld,
  input  logic [1:0]        beat_lanes,
  input  logic              ld_en,
  input  logic [TOT_W-1:0]  ld_data,
  output logic [MOVE_W-1:0] move_cnt,
  output logic [TOT_W-1:0]  total_cnt
);
  // Named internal events, visible to the bound checker.
  logic              beat_take;
  logic              wide_q;
  logic              chain_first;
  logic [STEP_W-1:0] move_inc;
  logic [STEP_W-1:0] total_inc;

  xbt_move_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mv_start   (mv_start),
    .mv_end     (mv_end),
    .wide_mode  (wide_mode),
    .dir_send   (dir_send),
    .chain_pend (chain_pend),
    .beat_vld   (beat_vld),
    .beat_take  (beat_take),
    .wide_q     (wide_q),
    .chain_first(chain_first)
  );

  xbt_step u_step (
    .wide_q     (wide_q),
    .chain_first(chain_first),
    .beat_lanes (beat_lanes),
    .move_inc   (move_inc),
    .total_inc  (total_inc)
  );

  xbt_accum #(.W(MOVE_W), .INC_W(STEP_W)) u_move (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (mv_start),
    .ld    (1'b0),
    .ld_val({MOVE_W{1'b0}}),
    .inc_en(beat_take),
    .inc   (move_inc),
    .q     (move_cnt)
  );

  xbt_accum #(.W(TOT_W), .INC_W(STEP_W)) u_total (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (1'b0),
    .ld    (ld_en),
    .ld_val(ld_data),
    .inc_en(beat_take),
    .inc   (total_inc),
    .q     (total_cnt)
  );
endmodule

// File: rtl/xbt_checker.sv
module xbt_checker #(
  parameter int MOVE_W = 24,
  parameter int TOT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mv_start,
  input logic              ld_en,
  input logic [TOT_W-1:0]  ld_data,
  input logic              beat_take,
  input logic              wide_q,
  input logic [MOVE_W-1:0] move_cnt,
  input logic [TOT_W-1:0]  total_cnt
);
  logic [MOVE_W-1:0] one_m;
  logic [MOVE_W-1:0] two_m;
  assign one_m = {{(MOVE_W-1){1'b0}}, 1'b1};
  assign two_m = {{(MOVE_W-2){1'b0}}, 2'b10};

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> (move_cnt == '0 && total_cnt == '0));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> move_cnt == '0);

  assert_narrow_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_take && !wide_q) |=> move_cnt == $past(move_cnt) + one_m);

  // R4 R5 R6: a wide beat moves the tally by one (chain) or two
  assert_wide_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_take && wide_q) |=>
      (move_cnt == $past(move_cnt) + one_m || move_cnt == $past(move_cnt) + two_m));

  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> total_cnt == $past(ld_data));

  assert_move_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_take && !mv_start) |=> $stable(move_cnt));

  assert_total_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_take && !ld_en) |=> $stable(total_cnt));
endmodule

bind xfer_byte_tally xbt_checker #(.MOVE_W(MOVE_W), .TOT_W(TOT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mv_start (mv_start),
  .ld_en    (ld_en),
  .ld_data  (ld_data),
  .beat_take(beat_take),
  .wide_q   (wide_q),
  .move_cnt (move_cnt),
  .total_cnt(total_cnt)
);

// File: tb/sim_xfer_byte_tally.sv
module sim_xfer_byte_tally;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mv_start = 1'b0, mv_end = 1'b0, wide_mode = 1'b0, dir_send = 1'b0;
  logic        chain_pend = 1'b0, beat_vld = 1'b0, ld_en = 1'b0;
  logic [1:0]  beat_lanes = 2'b00;
  logic [31:0] ld_data = '0;
  logic [23:0] move_cnt;
  logic [31:0] total_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench reference model state
  logic [23:0] e_move = '0;
  logic [31:0] e_total = '0;
  bit m_open = 0, m_wide = 0, m_chain = 0;

  always #2.5 clk = ~clk;

  xfer_byte_tally u0 (
    .clk(clk), .rst_n(rst_n), .mv_start(mv_start), .mv_end(mv_end),
    .wide_mode(wide_mode), .dir_send(dir_send), .chain_pend(chain_pend),
    .beat_vld(beat_vld), .beat_lanes(beat_lanes), .ld_en(ld_en), .ld_data(ld_data),
    .move_cnt(move_cnt), .total_cnt(total_cnt)
  );

  function automatic int tally_add(bit wide, bit first_chained);
    if (wide) return first_chained ? 1 : 2;
    return 1;
  endfunction

  function automatic int lanes_add(bit wide, logic [1:0] ln);
    int n = 0;
    if (ln[0]) n++;
    if (wide && ln[1]) n++;
    return n;
  endfunction

  task automatic check(string tag);
    checks++;
    if (move_cnt !== e_move) begin
      fails++;
      $display("FAIL %s move_cnt actual=%0d expected=%0d", tag, move_cnt, e_move);
    end
    checks++;
    if (total_cnt !== e_total) begin
      fails++;
      $display("FAIL %s total_cnt actual=%0d expected=%0d", tag, total_cnt, e_total);
    end
  endtask

  // One clock: inputs driven at a falling edge, outputs checked at the next.
  task automatic cyc(bit st, bit en, bit w, bit s, bit ch, bit bv, logic [1:0] ln,
                     bit ld, logic [31:0] ldv, string tag);
    bit take;
    mv_start = st; mv_end = en; wide_mode = w; dir_send = s; chain_pend = ch;
    beat_vld = bv; beat_lanes = ln; ld_en = ld; ld_data = ldv;
    take = m_open && bv && !st;
    if (ld) e_total = ldv;
    else if (take) e_total = e_total + 32'(lanes_add(m_wide, ln));
    if (st) begin
      e_move = '0; m_open = 1; m_wide = w; m_chain = ch && w && s;
    end else begin
      if (take) begin
        e_move = e_move + 24'(tally_add(m_wide, m_chain));
        m_chain = 0;
      end
      if (en) m_open = 0;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(string tag);
    cyc(0, 0, 0, 0, 0, 0, 2'b00, 0, 32'd0, tag);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    idle("R1 after reset");

    // R3: narrow receive, high lane ignored
    cyc(1, 0, 0, 0, 0, 0, 2'b00, 0, 0, "R2 start narrow");
    repeat (3) cyc(0, 0, 0, 0, 0, 1, 2'b01, 0, 0, "R3 narrow beat");
    cyc(0, 0, 0, 0, 0, 1, 2'b11, 0, 0, "R3 narrow high lane");
    cyc(0, 1, 0, 0, 0, 1, 2'b01, 0, 0, "R10 beat on end");
    // R10: beats after end ignored
    cyc(0, 0, 1, 1, 0, 1, 2'b11, 0, 0, "R10 beat after end");
    cyc(0, 0, 0, 0, 0, 1, 2'b01, 0, 0, "R10 tally held");

    // R4: wide send, 5 bytes -> tally 6
    cyc(1, 0, 1, 1, 0, 0, 2'b00, 0, 0, "R2 start wide send");
    cyc(0, 0, 1, 1, 0, 1, 2'b11, 0, 0, "R4 wide send");
    cyc(0, 0, 1, 1, 0, 1, 2'b11, 0, 0, "R4 wide send");
    cyc(0, 1, 1, 1, 0, 1, 2'b01, 0, 0, "R4 odd wide send");

    // R5: wide receive, 3 bytes -> tally 4
    cyc(1, 0, 1, 0, 0, 0, 2'b00, 0, 0, "R2 start wide recv");
    cyc(0, 0, 1, 0, 0, 1, 2'b11, 0, 0, "R5 wide recv");
    cyc(0, 1, 1, 0, 0, 1, 2'b01, 0, 0, "R5 odd wide recv");

    // R6: chained wide send, first beat counts 1 in tally, 2 in total
    cyc(1, 0, 1, 1, 1, 0, 2'b00, 0, 0, "R2 start chained");
    cyc(0, 0, 1, 1, 0, 1, 2'b11, 0, 0, "R6 chain first beat");
    cyc(0, 0, 1, 1, 0, 1, 2'b11, 0, 0, "R6 second beat");
    cyc(0, 1, 1, 1, 0, 1, 2'b01, 0, 0, "R6 last beat");
    // R6: chain flag on a receive has no effect
    cyc(1, 0, 1, 0, 1, 0, 2'b00, 0, 0, "R2 start recv chain");
    cyc(0, 1, 1, 0, 0, 1, 2'b11, 0, 0, "R6 recv ignores chain");

    // R11: flags change mid-move; R7 lane counting
    cyc(1, 0, 1, 0, 0, 0, 2'b00, 0, 0, "R2 start wide");
    cyc(0, 0, 0, 1, 1, 1, 2'b10, 0, 0, "R11 mode flip ignored");
    cyc(0, 0, 0, 0, 0, 1, 2'b00, 0, 0, "R7 no lanes");
    // R2: start with same-cycle beat
    cyc(1, 0, 0, 0, 0, 1, 2'b01, 0, 0, "R2 start beat dropped");
    cyc(0, 0, 0, 0, 0, 1, 2'b01, 0, 0, "R3 after restart");

    // R8: load alone, load with beat
    cyc(0, 0, 0, 0, 0, 0, 2'b00, 1, 32'd1000, "R8 load");
    cyc(0, 0, 0, 0, 0, 1, 2'b01, 1, 32'd77, "R8 load beats increment");

    // R9: wrap of running total
    cyc(1, 0, 1, 1, 0, 0, 2'b00, 1, 32'hFFFF_FFFF, "R8 load all ones");
    cyc(0, 1, 1, 1, 0, 1, 2'b11, 0, 0, "R9 total wraps");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom_range(0, 99) < 4) ? 1'b1 : 1'b0,
          ($urandom_range(0, 99) < 4) ? 1'b1 : 1'b0,
          1'($urandom), 1'($urandom), 1'($urandom),
          ($urandom_range(0, 99) < 70) ? 1'b1 : 1'b0,
          2'($urandom),
          ($urandom_range(0, 99) < 2) ? 1'b1 : 1'b0,
          $urandom, "R3 R4 R6 R7 R8 R10 random");
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule